// File: doc/BRIEF.md
# EPP Cycle Gate and Timeout Controller

This block turns register-bus accesses into byte-wide handshake cycles on an enhanced parallel-port bus. Two register offsets start bus cycles. Offset 3 runs one address-strobe cycle. Offset 4 runs data-strobe cycles and accepts accesses of 1, 2 or 4 bytes, which are sent or gathered least significant byte first. The block only starts a cycle when the stored control byte is exactly in the forward state (for writes) or the reverse state (for reads). Any other access to these two offsets is dropped without bus activity.

Each byte cycle raises a strobe and holds it until the peripheral raises `wait_i`. The strobe then drops for at least one cycle. If `wait_i` stays low for `TMO_CYC` cycles, the access is abandoned and a sticky timeout flag is set. Software reads this flag in status bit 0 and clears it by writing 1 there. The block also holds the control byte, the forward data byte and the bus direction. It reports a change of control or data on the pins with a one-cycle update pulse, and it never pulses for a write that repeats the stored value.

Top module: `epp_cycle_ctl`

## Requirements
- R1: After reset the bus is idle with `rdy_o` high and both strobes low. A control read returns 0xFFFFFFCC, a data read returns 0xFFFFFFFF, and status bit 0 reads 0. Reads of offsets 0..2 return the byte in bits 7:0 with bits 31:8 all ones.
- R2: A write to offset 3 or 4 produces strobe cycles only when (control & 0x2F) == 0x04. Any other write to these offsets makes no strobe and leaves the timeout flag unchanged.
- R3: A read of offset 3 or 4 produces strobe cycles only when (control & 0x2F) == 0x24. Otherwise it returns 0xFFFFFFFF with no strobe.
- R4: Offset 3 runs one cycle on `astb_o`. Offset 4 runs cycles on `dstb_o`, with size 0/1/2 giving 1/2/4 bytes and byte 0 first. Read bytes land at bits [8k+7:8k], and bytes not transferred read as 0xFF.
- R5: A strobe stays high until `wait_i` is sampled high, then goes low for at least one cycle before the next byte. The two strobes are never high together.
- R6: If `wait_i` is not seen within `TMO_CYC` strobe cycles, the strobe drops and the rest of the bytes are skipped. The timeout flag is then set, and skipped read bytes return 0xFF.
- R7: A status read returns {st_pins_i[7:1], timeout flag}. A status write with bit 0 = 1 clears the flag, and one with bit 0 = 0 leaves it set.
- R8: A control write stores the value with bits 7:6 forced to 1 and drives it on `ctl_o`. When bit 5 (direction, 1 = reverse) changes, `pd_oe_o` switches one cycle before `ctl_o` shows the new value.
- R9: A write to offset 0 or offset 2 whose value equals the stored byte gives no `dat_upd_o` / `ctl_upd_o` pulse. A differing value gives exactly one pulse.
- R10: `rdy_o` is low from the cycle after a request is accepted until the response. `rsp_o` is high for exactly one cycle per access.
- R11: A read of offset 0 returns the stored data byte when direction is 0, and returns `pd_i` when direction is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle, taken while rdy_o is high |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register offset |
| size_i | input | 2 | Offset 4 width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| wdata_i | input | 32 | Write data |
| rdy_o | output | 1 | Idle, ready for a request |
| rsp_o | output | 1 | Access complete, one-cycle pulse |
| rdata_o | output | 32 | Read data, valid with rsp_o |
| st_pins_i | input | 8 | Peripheral status lines |
| ctl_o | output | 8 | Stored control byte |
| ctl_upd_o | output | 1 | Pulse when ctl_o changes |
| dat_upd_o | output | 1 | Pulse when the stored data byte changes |
| pd_o | output | 8 | Parallel data out |
| pd_i | input | 8 | Parallel data in |
| pd_oe_o | output | 1 | Data bus output enable (forward) |
| astb_o | output | 1 | Address strobe, active high |
| dstb_o | output | 1 | Data strobe, active high |
| rnw_o | output | 1 | Cycle direction, 1 = read |
| wait_i | input | 1 | Peripheral handshake, high = byte accepted |

## Verification
A wrong gate decode shows on the same access: a strobe appears where none may, or a legal access returns all ones with no strobe. A stuck byte index or a bad handshake counter shows within one access, as bytes out of order on `pd_o`, a strobe held past `TMO_CYC`, or a response that never arrives. A timeout flag that is lost or not sticky shows on the next status read. A direction change in the wrong order shows in the same cycle that `ctl_o` changes.

// File: rtl/epp_cycle_pkg.sv
package epp_cycle_pkg;
  typedef enum logic [1:0] {A_IDLE, A_EPP, A_DIR, A_DONE} acc_st_e;
  typedef enum logic [1:0] {B_IDLE, B_STB, B_REL} byte_st_e;

  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd1;
  localparam logic [2:0] OFF_CTRL = 3'd2;
  localparam logic [2:0] OFF_EADR = 3'd3;
  localparam logic [2:0] OFF_EDAT = 3'd4;

  localparam logic [7:0] GATE_MASK = 8'h2F;
  localparam logic [7:0] GATE_FWD  = 8'h04;
  localparam logic [7:0] GATE_REV  = 8'h24;
  localparam logic [7:0] CTL_FIXED = 8'hC0;
  localparam logic [7:0] CTL_RST   = 8'hCC;
  localparam int         DIR_BIT   = 5;
endpackage

// File: rtl/epp_gate.sv
module epp_gate
  import epp_cycle_pkg::*;
(
  input  logic [7:0] ctl_i,
  input  logic       rd_i,
  output logic       ok_o
);
  logic [7:0] want;

  always_comb begin
    want = rd_i ? GATE_REV : GATE_FWD;
    ok_o = ((ctl_i & GATE_MASK) == want);
  end
endmodule

// File: rtl/epp_byte_seq.sv
module epp_byte_seq
  import epp_cycle_pkg::*;
#(
  parameter int TMO_CYC = 64,
  parameter int NBYTE   = 4,
  localparam int DW     = 8 * NBYTE,
  localparam int IDXW   = (NBYTE > 1) ? $clog2(NBYTE) : 1,
  localparam int CNTW   = $clog2(TMO_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            rd_i,
  input  logic            adr_i,
  input  logic [IDXW-1:0] last_i,
  input  logic [DW-1:0]   wbytes_i,
  input  logic            wait_i,
  input  logic [7:0]      pd_i,
  output logic            done_o,
  output logic            fail_o,
  output logic [DW-1:0]   rbytes_o,
  output logic            act_o,
  output logic            stb_o,
  output logic            adr_o,
  output logic            rnw_o,
  output logic [7:0]      pd_o
);
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(TMO_CYC - 1);

  byte_st_e        st_q, st_d;
  logic [IDXW-1:0] idx_q, idx_d, last_q, last_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            rd_q, rd_d, adr_q, adr_d;
  logic [DW-1:0]   wb_q, wb_d, rb_q, rb_d;
  logic            ld_en;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    last_d = last_q;
    cnt_d  = cnt_q;
    rd_d   = rd_q;
    adr_d  = adr_q;
    wb_d   = wb_q;
    rb_d   = rb_q;
    done_o = 1'b0;
    fail_o = 1'b0;
    unique case (st_q)
      B_IDLE: if (start_i) begin
        st_d   = B_STB;
        idx_d  = '0;
        cnt_d  = '0;
        last_d = last_i;
        rd_d   = rd_i;
        adr_d  = adr_i;
        wb_d   = wbytes_i;
        rb_d   = '1;
      end
      B_STB: begin
        if (wait_i) begin
          if (rd_q) rb_d[idx_q*8 +: 8] = pd_i;
          st_d = B_REL;
        end else if (cnt_q == CNT_LAST) begin
          fail_o = 1'b1;
          done_o = 1'b1;
          st_d   = B_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      B_REL: begin
        if (idx_q == last_q) begin
          done_o = 1'b1;
          st_d   = B_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
          cnt_d = '0;
          st_d  = B_STB;
        end
      end
      default: st_d = B_IDLE;
    endcase
  end

  assign ld_en = (st_q != B_IDLE) || start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= B_IDLE;
      idx_q  <= '0;
      last_q <= '0;
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      adr_q  <= 1'b0;
      wb_q   <= '0;
      rb_q   <= '1;
    end else if (ld_en) begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      last_q <= last_d;
      cnt_q  <= cnt_d;
      rd_q   <= rd_d;
      adr_q  <= adr_d;
      wb_q   <= wb_d;
      rb_q   <= rb_d;
    end
  end

  assign act_o    = (st_q != B_IDLE);
  assign stb_o    = (st_q == B_STB);
  assign adr_o    = adr_q;
  assign rnw_o    = rd_q;
  assign pd_o     = wb_q[idx_q*8 +: 8];
  assign rbytes_o = rb_q;
endmodule

// File: rtl/epp_cycle_ctl.sv
module epp_cycle_ctl
  import epp_cycle_pkg::*;
#(
  parameter int TMO_CYC = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic        wr_i,
  input  logic [2:0]  addr_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  output logic        rdy_o,
  output logic        rsp_o,
  output logic [31:0] rdata_o,
  input  logic [7:0]  st_pins_i,
  output logic [7:0]  ctl_o,
  output logic        ctl_upd_o,
  output logic        dat_upd_o,
  output logic [7:0]  pd_o,
  input  logic [7:0]  pd_i,
  output logic        pd_oe_o,
  output logic        astb_o,
  output logic        dstb_o,
  output logic        rnw_o,
  input  logic        wait_i
);
  localparam int NBYTE = 4;
  localparam int IDXW  = $clog2(NBYTE);

  acc_st_e     st_q, st_d;
  logic [7:0]  ctl_q, ctl_d, pend_q, pend_d, dat_q, dat_d, nv;
  logic        dir_q, dir_d, tmo_q, tmo_d, cupd_q, cupd_d, dupd_q, dupd_d;
  logic [31:0] rdat_q, rdat_d;
  logic        gate_ok, go;
  logic [IDXW-1:0] last_idx;
  logic        sq_done, sq_fail, sq_act, sq_stb, sq_adr, sq_rnw;
  logic [31:0] sq_rb;
  logic [7:0]  sq_pd;

  epp_gate u_gate (.ctl_i(ctl_q), .rd_i(!wr_i), .ok_o(gate_ok));

  always_comb begin
    if (addr_i == OFF_EADR) last_idx = '0;
    else if (size_i == 2'd0) last_idx = IDXW'(0);
    else if (size_i == 2'd1) last_idx = IDXW'(1);
    else last_idx = IDXW'(NBYTE - 1);
  end

  epp_byte_seq #(.TMO_CYC(TMO_CYC), .NBYTE(NBYTE)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(go), .rd_i(!wr_i),
    .adr_i(addr_i == OFF_EADR), .last_i(last_idx), .wbytes_i(wdata_i),
    .wait_i(wait_i), .pd_i(pd_i), .done_o(sq_done), .fail_o(sq_fail),
    .rbytes_o(sq_rb), .act_o(sq_act), .stb_o(sq_stb), .adr_o(sq_adr),
    .rnw_o(sq_rnw), .pd_o(sq_pd)
  );

  always_comb begin
    st_d   = st_q;
    ctl_d  = ctl_q;
    pend_d = pend_q;
    dat_d  = dat_q;
    dir_d  = dir_q;
    tmo_d  = tmo_q;
    rdat_d = rdat_q;
    cupd_d = 1'b0;
    dupd_d = 1'b0;
    go     = 1'b0;
    nv     = wdata_i[7:0] | CTL_FIXED;
    unique case (st_q)
      A_IDLE: if (req_i) begin
        rdat_d = '1;
        st_d   = A_DONE;
        case (addr_i)
          OFF_DATA: begin
            if (wr_i) begin
              if (wdata_i[7:0] != dat_q) begin
                dat_d  = wdata_i[7:0];
                dupd_d = 1'b1;
              end
            end else begin
              rdat_d[7:0] = dir_q ? pd_i : dat_q;
            end
          end
          OFF_STAT: begin
            if (wr_i) begin
              if (wdata_i[0]) tmo_d = 1'b0;
            end else begin
              rdat_d[7:0] = (st_pins_i & 8'hFE) | {7'd0, tmo_q};
            end
          end
          OFF_CTRL: begin
            if (wr_i) begin
              if (nv != ctl_q) begin
                if (nv[DIR_BIT] != ctl_q[DIR_BIT]) begin
                  dir_d  = nv[DIR_BIT];
                  pend_d = nv;
                  st_d   = A_DIR;
                end else begin
                  ctl_d  = nv;
                  cupd_d = 1'b1;
                end
              end
            end else begin
              rdat_d[7:0] = ctl_q;
            end
          end
          OFF_EADR, OFF_EDAT: begin
            if (gate_ok) begin
              go   = 1'b1;
              st_d = A_EPP;
            end
          end
          default: ;
        endcase
      end
      A_DIR: begin
        ctl_d  = pend_q;
        cupd_d = 1'b1;
        st_d   = A_DONE;
      end
      A_EPP: if (sq_done) begin
        if (sq_fail) tmo_d = 1'b1;
        rdat_d = sq_rb;
        st_d   = A_DONE;
      end
      A_DONE: st_d = A_IDLE;
      default: st_d = A_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= A_IDLE;
      ctl_q  <= CTL_RST;
      pend_q <= CTL_RST;
      dat_q  <= 8'hFF;
      dir_q  <= 1'b0;
      tmo_q  <= 1'b0;
      rdat_q <= '1;
      cupd_q <= 1'b0;
      dupd_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ctl_q  <= ctl_d;
      pend_q <= pend_d;
      dat_q  <= dat_d;
      dir_q  <= dir_d;
      tmo_q  <= tmo_d;
      rdat_q <= rdat_d;
      cupd_q <= cupd_d;
      dupd_q <= dupd_d;
    end
  end

  assign rdy_o     = (st_q == A_IDLE);
  assign rsp_o     = (st_q == A_DONE);
  assign rdata_o   = rdat_q;
  assign ctl_o     = ctl_q;
  assign ctl_upd_o = cupd_q;
  assign dat_upd_o = dupd_q;
  assign pd_o      = (sq_act && !sq_rnw) ? sq_pd : dat_q;
  assign pd_oe_o   = !dir_q;
  assign astb_o    = sq_stb && sq_adr;
  assign dstb_o    = sq_stb && !sq_adr;
  assign rnw_o     = sq_rnw;
endmodule

// File: rtl/epp_cycle_ctl_chk.sv
module epp_cycle_ctl_chk #(
  parameter int TMO_CYC = 64,
  localparam int RUNW   = $clog2(TMO_CYC + 2)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rdy_o,
  input logic       rsp_o,
  input logic [7:0] ctl_o,
  input logic       ctl_upd_o,
  input logic       pd_oe_o,
  input logic       astb_o,
  input logic       dstb_o,
  input logic       rnw_o
);
  logic            strobe;
  logic [RUNW-1:0] run_q;

  assign strobe = astb_o || dstb_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (!strobe) run_q <= '0;
    else if (run_q <= RUNW'(TMO_CYC)) run_q <= run_q + 1'b1;
  end

  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({astb_o, dstb_o}));

  assert_wr_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !rnw_o) |-> ((ctl_o & 8'h2F) == 8'h04));

  assert_rd_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && rnw_o) |-> ((ctl_o & 8'h2F) == 8'h24));

  assert_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (run_q < RUNW'(TMO_CYC)));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> !rdy_o);

  assert_rsp_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_o |=> !rsp_o);

  assert_dir_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_o[5] != $past(ctl_o[5])) |-> ($past(pd_oe_o) == !ctl_o[5]));

  assert_upd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_upd_o |-> (ctl_o != $past(ctl_o)));
endmodule

bind epp_cycle_ctl epp_cycle_ctl_chk #(.TMO_CYC(TMO_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy_o(rdy_o), .rsp_o(rsp_o), .ctl_o(ctl_o),
  .ctl_upd_o(ctl_upd_o), .pd_oe_o(pd_oe_o), .astb_o(astb_o),
  .dstb_o(dstb_o), .rnw_o(rnw_o)
);

// File: tb/epp_cycle_ctl_tb.sv
module epp_cycle_ctl_tb;
  localparam int CLK_PER = 10;
  localparam int TMO     = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_i = 1'b0, wr_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [1:0] size_i = '0;
  logic [31:0] wdata_i = '0;
  logic rdy_o, rsp_o, ctl_upd_o, dat_upd_o, pd_oe_o, astb_o, dstb_o, rnw_o;
  logic [31:0] rdata_o;
  logic [7:0] st_pins_i = 8'hA8, ctl_o, pd_o, pd_i;
  logic wait_r = 1'b0, stb_prev = 1'b0;
  logic [7:0] rd_base = 8'h40, rd_cnt = 8'h00;

  int errs = 0, nchk = 0, nstb = 0, ncupd = 0, ndupd = 0, scnt = 0, dly = 2;
  bit never = 0;
  logic [31:0] exp_q[$];
  bit          use_q[$];
  string       tag_q[$];
  logic [8:0]  expw_q[$];
  int          t_oe = -1, t_dir = -1, cyc = 0;

  always #(CLK_PER/2) clk = ~clk;
  assign pd_i = rd_base + rd_cnt;

  epp_cycle_ctl #(.TMO_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
    .size_i(size_i), .wdata_i(wdata_i), .rdy_o(rdy_o), .rsp_o(rsp_o),
    .rdata_o(rdata_o), .st_pins_i(st_pins_i), .ctl_o(ctl_o),
    .ctl_upd_o(ctl_upd_o), .dat_upd_o(dat_upd_o), .pd_o(pd_o), .pd_i(pd_i),
    .pd_oe_o(pd_oe_o), .astb_o(astb_o), .dstb_o(dstb_o), .rnw_o(rnw_o),
    .wait_i(wait_r)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // peripheral model: handshake after dly strobe cycles, write-byte scoreboard
  always @(posedge clk) begin
    if (astb_o || dstb_o) begin
      if (!stb_prev) nstb++;
      if (wait_r && !rnw_o) begin
        if (expw_q.size() == 0) chk(0, "R4 unexpected byte", {23'd0, astb_o, pd_o}, 32'd0);
        else chk(expw_q[0] == {astb_o, pd_o}, "R4 write byte order", {23'd0, astb_o, pd_o},
                 {23'd0, expw_q[0]});
        if (expw_q.size() != 0) void'(expw_q.pop_front());
      end
      if (wait_r && rnw_o) rd_cnt <= rd_cnt + 8'd1;
      if (!never && scnt == dly) wait_r <= 1'b1;
      scnt++;
    end else begin
      scnt = 0;
      wait_r <= 1'b0;
    end
    stb_prev <= astb_o || dstb_o;
  end

  // response monitor
  always @(negedge clk) begin
    cyc++;
    if (ctl_upd_o) ncupd++;
    if (dat_upd_o) ndupd++;
    if (rsp_o) begin
      if (exp_q.size() == 0) chk(0, "R10 stray response", rdata_o, 32'd0);
      else begin
        if (use_q[0]) chk(rdata_o == exp_q[0], tag_q[0], rdata_o, exp_q[0]);
        void'(exp_q.pop_front()); void'(use_q.pop_front()); void'(tag_q.pop_front());
      end
    end
  end

  // direction order tracking for R8
  logic oe_d = 1'b1, dir_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n && oe_d && !pd_oe_o) t_oe = cyc;
    if (rst_n && !dir_d && ctl_o[5]) t_dir = cyc;
    oe_d  <= pd_oe_o;
    dir_d <= ctl_o[5];
  end

  task automatic acc(input bit w, input logic [2:0] a, input logic [1:0] sz,
                     input logic [31:0] d, input logic [31:0] e, input bit c, input string tag);
    @(negedge clk);
    while (!rdy_o) @(negedge clk);
    exp_q.push_back(e); use_q.push_back(c); tag_q.push_back(tag);
    req_i = 1'b1; wr_i = w; addr_i = a; size_i = sz; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0;
    if (a == 3'd4 && w) chk(!rdy_o, "R10 busy after accept", {31'd0, rdy_o}, 32'd0);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    int s0, c0;
    #(CLK_PER*3) rst_n = 1'b1;
    @(negedge clk);
    chk(rdy_o && !astb_o && !dstb_o, "R1 idle after reset", {29'd0, rdy_o, astb_o, dstb_o}, 32'd4);
    acc(0, 3'd2, 0, 0, 32'hFFFF_FFCC, 1, "R1 control reset");
    acc(0, 3'd1, 0, 0, 32'hFFFF_FFA8, 1, "R1 status reset");
    acc(0, 3'd0, 0, 0, 32'hFFFF_FFFF, 1, "R1 data reset");
    // R2: write while gate closed
    s0 = nstb;
    acc(1, 3'd4, 2, 32'h1234_5678, 0, 0, "R2");
    chk(nstb == s0, "R2 no strobe when closed", nstb, s0);
    acc(0, 3'd1, 0, 0, 32'hFFFF_FFA8, 1, "R2 flag untouched");
    // R8/R9 control writes
    c0 = ncupd;
    acc(1, 3'd2, 0, 32'h04, 0, 0, "R8");
    acc(0, 3'd2, 0, 0, 32'hFFFF_FFC4, 1, "R8 fixed bits");
    acc(1, 3'd2, 0, 32'hC4, 0, 0, "R9");
    chk(ncupd == c0 + 1, "R9 control pulses", ncupd, c0 + 1);
    c0 = ndupd;
    acc(1, 3'd0, 0, 32'h12, 0, 0, "R9");
    acc(1, 3'd0, 0, 32'h12, 0, 0, "R9");
    chk(ndupd == c0 + 1, "R9 data pulses", ndupd, c0 + 1);
    acc(0, 3'd0, 0, 0, 32'hFFFF_FF12, 1, "R11 forward data read");
    // R4/R5 forward cycles
    expw_q.push_back(9'h15A);
    acc(1, 3'd3, 2, 32'h5A, 0, 0, "R4");
    dly = 0;
    expw_q.push_back(9'h011); expw_q.push_back(9'h022);
    expw_q.push_back(9'h033); expw_q.push_back(9'h044);
    s0 = nstb;
    acc(1, 3'd4, 2, 32'h4433_2211, 0, 0, "R4");
    chk(nstb == s0 + 4, "R5 four strobes", nstb, s0 + 4);
    dly = 3;
    expw_q.push_back(9'h0EF); expw_q.push_back(9'h0BE);
    acc(1, 3'd4, 1, 32'h0000_BEEF, 0, 0, "R4");
    chk(expw_q.size() == 0, "R4 all bytes seen", expw_q.size(), 0);
    acc(0, 3'd1, 0, 0, 32'hFFFF_FFA8, 1, "R7 no timeout yet");
    // R6 write timeout
    never = 1; s0 = nstb;
    acc(1, 3'd4, 2, 32'hA1B2_C3D4, 0, 0, "R6");
    chk(nstb == s0 + 1, "R6 rest abandoned", nstb, s0 + 1);
    acc(0, 3'd1, 0, 0, 32'hFFFF_FFA9, 1, "R6 flag set");
    acc(1, 3'd1, 0, 32'h00, 0, 0, "R7");
    acc(0, 3'd1, 0, 0, 32'hFFFF_FFA9, 1, "R7 bit0=0 keeps flag");
    acc(1, 3'd1, 0, 32'h01, 0, 0, "R7");
    acc(0, 3'd1, 0, 0, 32'hFFFF_FFA8, 1, "R7 clear");
    never = 0; dly = 1;
    // R3 read while gate closed
    s0 = nstb;
    acc(0, 3'd4, 2, 0, 32'hFFFF_FFFF, 1, "R3 closed read");
    chk(nstb == s0, "R3 no strobe", nstb, s0);
    // R8 direction change
    acc(1, 3'd2, 0, 32'h24, 0, 0, "R8");
    chk(!pd_oe_o && ctl_o == 8'hE4, "R8 reverse state", {23'd0, pd_oe_o, ctl_o}, 32'hE4);
    chk(t_oe >= 0 && t_dir == t_oe + 1, "R8 bus turns first", t_dir, t_oe + 1);
    // reverse cycles
    rd_base = 8'h40; rd_cnt = 8'h00;
    acc(0, 3'd4, 2, 0, 32'h4342_4140, 1, "R4 four byte read");
    rd_cnt = 8'h00;
    acc(0, 3'd4, 1, 0, 32'hFFFF_4140, 1, "R4 two byte read");
    rd_cnt = 8'h00;
    acc(0, 3'd3, 2, 0, 32'hFFFF_FF40, 1, "R4 address read");
    rd_cnt = 8'h00; never = 1;
    acc(0, 3'd4, 2, 0, 32'hFFFF_FFFF, 1, "R6 read timeout ones");
    acc(0, 3'd1, 0, 0, 32'hFFFF_FFA9, 1, "R6 read flag set");
    never = 0;
    rd_base = 8'h77; rd_cnt = 8'h00;
    acc(0, 3'd0, 0, 0, 32'hFFFF_FF77, 1, "R11 reverse data read");
    // R2 write while in reverse state is dropped
    s0 = nstb;
    acc(1, 3'd3, 0, 32'h99, 0, 0, "R2");
    chk(nstb == s0, "R2 write in reverse dropped", nstb, s0);
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    #(CLK_PER * 100000);
    errs++; nchk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule